// File: doc/BRIEF.md
# SMM Resume Controller

This block holds the resume-control state of a processor's system management mode. When a management interrupt is accepted, it does three things. It records whether the core was sitting in HALT, clears the I/O restart slot, and latches a 32-bit I/O trap word. The trap word carries the trapped port address, a flag telling whether the trapping instruction was a genuine I/O instruction, and the read/write direction. The block also keeps two context facts from entry: whether the interrupt came on an I/O instruction boundary, and whether it was the second of a back-to-back pair.

While the block is in management mode, handler code reads and writes the slots through a small word-addressed port. When the resume pulse arrives, the block compares the halt flag's entry value with its current value and looks at the I/O restart slot. From these it picks one resume path. It reports that path for one cycle as a one-hot code, together with an error flag for any combination that is not allowed. It then returns to normal mode.

Top module: `smm_resume_ctrl`

## Requirements
- R1: After reset, `smm_active` and `res_valid` are 0, and a read of any slot address returns 0.
- R2: An accepted `smi_entry` pulse raises `smm_active` from the next cycle. At the same time the halt slot (address 16'h7F02, bit 0) takes the value of `halted`, and the I/O restart slot (address 16'h7F00, bits 7:0) becomes 8'h00.
- R3: The trap word reads as two words. Address 16'h7F0A returns `io_addr`. Address 16'h7F08 returns bit 0 = `io_rw`, bit 1 = the valid-I/O flag, and zeros in bits 15:2. When `back_to_back` is 1 at entry, both words read as 0.
- R4: The valid-I/O flag is 1 only for `insn_class` codes 1 to 6 (IN, OUT, INS, OUTS, REP INS, REP OUTS). Codes 0 and 7 store 0.
- R5: In management mode, a write to 16'h7F02 updates only bit 0, and a write to 16'h7F00 updates only bits 7:0. Reserved bits and unmapped addresses always read 0, and the trap words are read-only.
- R6: Writes while `smm_active` is 0, or in the cycle of `rsm`, leave every slot unchanged.
- R7: An `rsm` pulse in management mode gives `res_valid` = 1 for exactly one cycle, starting the cycle after the pulse. In that same cycle `smm_active` drops to 0. The action code is `res_act` bit 0 = next instruction, bit 1 = after HALT, bit 2 = re-enter HALT (fetch HALT again and run a halt bus cycle), bit 3 = re-execute trapped I/O.
- R8: With a legal I/O slot of 8'h00, the halt bit decides the action. Entry 1 and exit 1 gives re-enter HALT. Entry 1 and exit 0 gives after HALT. Entry 0 and exit 0 gives next instruction.
- R9: Halt bit 0 at entry and 1 at exit sets `res_err` = 1 with `res_act` = 0.
- R10: An I/O slot of 8'hFF gives the re-execute action when the entry was on an I/O boundary and was not back-to-back. It takes priority over the halt path.
- R11: An I/O slot of 8'hFF with no I/O boundary, or with back-to-back entry, is an error. So is any slot value other than 8'h00 or 8'hFF. An error has `res_act` = 0.
- R12: `smi_entry` while in management mode is ignored and captures nothing. `rsm` outside management mode produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_entry | input | 1 | Management interrupt accepted, one-cycle pulse |
| halted | input | 1 | Core was in HALT when interrupted |
| io_boundary | input | 1 | Interrupt came on an I/O instruction boundary |
| back_to_back | input | 1 | Second interrupt of a back-to-back pair |
| io_addr | input | 16 | Trapped I/O port address |
| io_rw | input | 1 | Trapped access direction |
| insn_class | input | 3 | Class code of the trapping instruction |
| hreg_addr | input | 16 | Handler word address for reads and writes |
| hreg_wr | input | 1 | Handler write enable |
| hreg_wdata | input | 16 | Handler write data |
| hreg_rdata | output | 16 | Handler read data (combinational) |
| rsm | input | 1 | Resume request, one-cycle pulse |
| smm_active | output | 1 | Block is in management mode |
| res_valid | output | 1 | Resume result valid, one cycle |
| res_act | output | 4 | One-hot resume action |
| res_err | output | 1 | Illegal slot configuration at resume |

## Verification
The resume decision is driven through all four halt entry/exit pairs with the I/O slot clear, which separates the three legal halt paths from the forbidden one. The I/O slot is then set to 8'hFF under three entry contexts: a clean boundary, no boundary, and back-to-back. This shows that re-execution depends on entry context and not on the slot value alone, and that it overrides a pending halt path. A stray slot value of 8'h5A, every instruction class code, and a non-zero address with both directions check the trap capture and the error catch-all.

// File: rtl/smm_resume_pkg.sv
package smm_resume_pkg;

    typedef enum logic [0:0] {
        MODE_NORMAL = 1'b0,
        MODE_SMM    = 1'b1
    } smm_mode_e;

    localparam int ACT_W       = 4;
    localparam int ACT_NEXT    = 0;
    localparam int ACT_AFTER   = 1;
    localparam int ACT_REHALT  = 2;
    localparam int ACT_IO_REEX = 3;

    localparam int IOS_W = 8;
    localparam logic [IOS_W-1:0] IOS_CLEAR = 8'h00;
    localparam logic [IOS_W-1:0] IOS_REEX  = 8'hFF;

    localparam int CLASS_W = 3;
    localparam logic [CLASS_W-1:0] CLS_IN       = 3'd1;
    localparam logic [CLASS_W-1:0] CLS_REP_OUTS = 3'd6;

    function automatic logic class_is_io(input logic [CLASS_W-1:0] cls);
        return (cls >= CLS_IN) && (cls <= CLS_REP_OUTS);
    endfunction

endpackage

// File: rtl/smm_slot_file.sv
module smm_slot_file
    import smm_resume_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int IOA_W  = 16,
    parameter logic [ADDR_W-1:0] IO_SLOT_OFS = 16'h7F00,
    parameter logic [ADDR_W-1:0] HALT_OFS    = 16'h7F02,
    parameter logic [ADDR_W-1:0] TRAP_LO_OFS = 16'h7F08,
    parameter logic [ADDR_W-1:0] TRAP_HI_OFS = 16'h7F0A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap,
    input  logic                halted,
    input  logic                io_boundary,
    input  logic                back_to_back,
    input  logic [IOA_W-1:0]    io_addr,
    input  logic                io_rw,
    input  logic [CLASS_W-1:0]  insn_class,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                halt_entry,
    output logic                halt_now,
    output logic [IOS_W-1:0]    io_slot,
    output logic                io_bound_entry,
    output logic                b2b_entry
);
    localparam int TRAP_W = IOA_W + DATA_W;
    localparam int RSV_W  = DATA_W - 2;

    typedef struct packed {
        logic              halt_entry;
        logic              halt_now;
        logic [IOS_W-1:0]  io_slot;
        logic              io_bound;
        logic              b2b;
        logic [TRAP_W-1:0] trap;
    } slot_regs_t;

    slot_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cap) begin
            regs_d.halt_entry = halted;
            regs_d.halt_now   = halted;
            regs_d.io_slot    = IOS_CLEAR;
            regs_d.io_bound   = io_boundary;
            regs_d.b2b        = back_to_back;
            if (back_to_back)
                regs_d.trap = '0;
            else
                regs_d.trap = {io_addr, {RSV_W{1'b0}}, class_is_io(insn_class), io_rw};
        end else if (wr_en) begin
            if (addr == HALT_OFS)
                regs_d.halt_now = wdata[0];
            if (addr == IO_SLOT_OFS)
                regs_d.io_slot = wdata[IOS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            HALT_OFS:    rdata[0] = regs_q.halt_now;
            IO_SLOT_OFS: rdata[IOS_W-1:0] = regs_q.io_slot;
            TRAP_LO_OFS: rdata = regs_q.trap[DATA_W-1:0];
            TRAP_HI_OFS: rdata = DATA_W'(regs_q.trap[TRAP_W-1:DATA_W]);
            default:     rdata = '0;
        endcase
    end

    assign halt_entry     = regs_q.halt_entry;
    assign halt_now       = regs_q.halt_now;
    assign io_slot        = regs_q.io_slot;
    assign io_bound_entry = regs_q.io_bound;
    assign b2b_entry      = regs_q.b2b;

    AST_ENTRY_IO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (io_slot == IOS_CLEAR)); // R2
    AST_ENTRY_HALT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (halt_now == $past(halted) && halt_entry == $past(halted))); // R2
    AST_B2B_TRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && back_to_back) |=> (regs_q.trap == '0)); // R3
    AST_TRAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(regs_q.trap)); // R5

endmodule

// File: rtl/smm_resume_decide.sv
module smm_resume_decide
    import smm_resume_pkg::*;
(
    input  logic              halt_entry,
    input  logic              halt_now,
    input  logic [IOS_W-1:0]  io_slot,
    input  logic              io_bound_entry,
    input  logic              b2b_entry,
    output logic [ACT_W-1:0]  act,
    output logic              err
);
    logic io_req;
    logic io_clr;
    logic err_halt;
    logic err_io;

    always_comb begin
        io_req   = (io_slot == IOS_REEX);
        io_clr   = (io_slot == IOS_CLEAR);
        err_halt = !halt_entry && halt_now;
        err_io   = (!io_req && !io_clr) || (io_req && (!io_bound_entry || b2b_entry));
        err      = err_halt || err_io;
        act      = '0;
        if (!err) begin
            if (io_req)
                act[ACT_IO_REEX] = 1'b1;
            else if (halt_entry && halt_now)
                act[ACT_REHALT] = 1'b1;
            else if (halt_entry)
                act[ACT_AFTER] = 1'b1;
            else
                act[ACT_NEXT] = 1'b1;
        end
    end

    always_comb begin
        AST_ACT_EXCLUSIVE: assert ($countones(act) == (err ? 0 : 1)); // R7
    end

endmodule

// File: rtl/smm_resume_ctrl.sv
module smm_resume_ctrl
    import smm_resume_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int IOA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smi_entry,
    input  logic               halted,
    input  logic               io_boundary,
    input  logic               back_to_back,
    input  logic [IOA_W-1:0]   io_addr,
    input  logic               io_rw,
    input  logic [2:0]         insn_class,
    input  logic [ADDR_W-1:0]  hreg_addr,
    input  logic               hreg_wr,
    input  logic [DATA_W-1:0]  hreg_wdata,
    output logic [DATA_W-1:0]  hreg_rdata,
    input  logic               rsm,
    output logic               smm_active,
    output logic               res_valid,
    output logic [3:0]         res_act,
    output logic               res_err
);
    typedef struct packed {
        smm_mode_e         mode;
        logic              res_valid;
        logic [ACT_W-1:0]  res_act;
        logic              res_err;
    } ctrl_regs_t;

    ctrl_regs_t ctrl_d, ctrl_q;

    logic              cap;
    logic              wr_en;
    logic              halt_entry;
    logic              halt_now;
    logic [IOS_W-1:0]  io_slot;
    logic              io_bound_entry;
    logic              b2b_entry;
    logic [ACT_W-1:0]  dec_act;
    logic              dec_err;

    assign cap   = (ctrl_q.mode == MODE_NORMAL) && smi_entry;
    assign wr_en = (ctrl_q.mode == MODE_SMM) && hreg_wr && !rsm;

    smm_slot_file #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IOA_W  (IOA_W)
    ) i_slots (
        .clk            (clk),
        .rst_n          (rst_n),
        .cap            (cap),
        .halted         (halted),
        .io_boundary    (io_boundary),
        .back_to_back   (back_to_back),
        .io_addr        (io_addr),
        .io_rw          (io_rw),
        .insn_class     (insn_class),
        .wr_en          (wr_en),
        .addr           (hreg_addr),
        .wdata          (hreg_wdata),
        .rdata          (hreg_rdata),
        .halt_entry     (halt_entry),
        .halt_now       (halt_now),
        .io_slot        (io_slot),
        .io_bound_entry (io_bound_entry),
        .b2b_entry      (b2b_entry)
    );

    smm_resume_decide i_decide (
        .halt_entry     (halt_entry),
        .halt_now       (halt_now),
        .io_slot        (io_slot),
        .io_bound_entry (io_bound_entry),
        .b2b_entry      (b2b_entry),
        .act            (dec_act),
        .err            (dec_err)
    );

    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.res_valid = 1'b0;
        ctrl_d.res_act   = '0;
        ctrl_d.res_err   = 1'b0;
        unique case (ctrl_q.mode)
            MODE_NORMAL: begin
                if (smi_entry)
                    ctrl_d.mode = MODE_SMM;
            end
            MODE_SMM: begin
                if (rsm) begin
                    ctrl_d.mode      = MODE_NORMAL;
                    ctrl_d.res_valid = 1'b1;
                    ctrl_d.res_act   = dec_act;
                    ctrl_d.res_err   = dec_err;
                end
            end
            default: ctrl_d.mode = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.mode      <= MODE_NORMAL;
            ctrl_q.res_valid <= 1'b0;
            ctrl_q.res_act   <= '0;
            ctrl_q.res_err   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign smm_active = (ctrl_q.mode == MODE_SMM);
    assign res_valid  = ctrl_q.res_valid;
    assign res_act    = ctrl_q.res_act;
    assign res_err    = ctrl_q.res_err;

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R7
    AST_RESULT_LEAVES_SMM: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !smm_active); // R7
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smm_active && !smi_entry) |=> ($stable(io_slot) && $stable(halt_now))); // R6
    AST_ILLEGAL_HALT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_active && rsm && !halt_entry && halt_now) |=> (res_err && res_act == '0)); // R9
    AST_STRAY_RSM: assert property (@(posedge clk) disable iff (!rst_n)
        (!smm_active && rsm) |=> !res_valid); // R12
    AST_NESTED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_active && smi_entry && !rsm && !hreg_wr) |=> ($stable(io_slot) && $stable(halt_entry))); // R12

endmodule

// File: tb/test_smm_resume_ctrl.sv
`timescale 1ns/1ps
module test_smm_resume_ctrl;

    localparam logic [15:0] A_IO   = 16'h7F00;
    localparam logic [15:0] A_HALT = 16'h7F02;
    localparam logic [15:0] A_TLO  = 16'h7F08;
    localparam logic [15:0] A_THI  = 16'h7F0A;
    localparam logic [3:0]  K_NEXT = 4'b0001;
    localparam logic [3:0]  K_AFT  = 4'b0010;
    localparam logic [3:0]  K_RH   = 4'b0100;
    localparam logic [3:0]  K_IO   = 4'b1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smi_entry = 1'b0;
    logic        halted = 1'b0;
    logic        io_boundary = 1'b0;
    logic        back_to_back = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rw = 1'b0;
    logic [2:0]  insn_class = '0;
    logic [15:0] hreg_addr = '0;
    logic        hreg_wr = 1'b0;
    logic [15:0] hreg_wdata = '0;
    logic [15:0] hreg_rdata;
    logic        rsm = 1'b0;
    logic        smm_active;
    logic        res_valid;
    logic [3:0]  res_act;
    logic        res_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smm_resume_ctrl i_smm_resume_ctrl (
        .clk(clk), .rst_n(rst_n), .smi_entry(smi_entry), .halted(halted),
        .io_boundary(io_boundary), .back_to_back(back_to_back), .io_addr(io_addr),
        .io_rw(io_rw), .insn_class(insn_class), .hreg_addr(hreg_addr), .hreg_wr(hreg_wr),
        .hreg_wdata(hreg_wdata), .hreg_rdata(hreg_rdata), .rsm(rsm),
        .smm_active(smm_active), .res_valid(res_valid), .res_act(res_act), .res_err(res_err)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic enter(input logic h, input logic b, input logic bb,
                         input logic [15:0] a, input logic rw, input logic [2:0] c);
        @(negedge clk);
        halted = h; io_boundary = b; back_to_back = bb;
        io_addr = a; io_rw = rw; insn_class = c; smi_entry = 1'b1;
        @(negedge clk);
        smi_entry = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        hreg_addr = a; hreg_wdata = d; hreg_wr = 1'b1;
        @(negedge clk);
        hreg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
        hreg_addr = a;
        #1;
        check(tag, {16'h0, hreg_rdata}, {16'h0, exp});
    endtask

    task automatic resume_chk(input string tag, input logic [3:0] act, input logic err);
        @(negedge clk);
        rsm = 1'b1;
        @(negedge clk);
        rsm = 1'b0;
        check({tag, " valid"}, {31'h0, res_valid}, 32'h1);
        check({tag, " act"}, {28'h0, res_act}, {28'h0, act});
        check({tag, " err"}, {31'h0, res_err}, {31'h0, err});
        check({tag, " R7 active drops"}, {31'h0, smm_active}, 32'h0);
        @(negedge clk);
        check({tag, " R7 one cycle"}, {31'h0, res_valid}, 32'h0);
    endtask

    task automatic t_reset();
        check("R1 active", {31'h0, smm_active}, 32'h0);
        check("R1 valid", {31'h0, res_valid}, 32'h0);
        rd_chk("R1 io slot", A_IO, 16'h0);
        rd_chk("R1 halt slot", A_HALT, 16'h0);
        rd_chk("R1 trap hi", A_THI, 16'h0);
    endtask

    task automatic t_entry();
        enter(1'b1, 1'b0, 1'b0, 16'h03F8, 1'b1, 3'd2);
        check("R2 active", {31'h0, smm_active}, 32'h1);
        rd_chk("R2 halt set", A_HALT, 16'h0001);
        rd_chk("R2 io clear", A_IO, 16'h0000);
        rd_chk("R3 trap hi", A_THI, 16'h03F8);
        rd_chk("R3 trap lo", A_TLO, 16'h0003);
        resume_chk("R8 rehalt", K_RH, 1'b0);
    endtask

    task automatic t_trap_b2b();
        enter(1'b0, 1'b1, 1'b1, 16'hBEEF, 1'b1, 3'd1);
        rd_chk("R3 b2b hi", A_THI, 16'h0);
        rd_chk("R3 b2b lo", A_TLO, 16'h0);
        rd_chk("R2 halt clear", A_HALT, 16'h0);
        wr(A_IO, 16'h00FF);
        resume_chk("R11 b2b io", 4'b0000, 1'b1);
    endtask

    task automatic t_classes();
        for (int c = 0; c < 8; c++) begin
            enter(1'b0, 1'b1, 1'b0, 16'h0080, 1'b0, c[2:0]);
            rd_chk("R4 valid flag", A_TLO, {14'h0, (c >= 1 && c <= 6), 1'b0});
            resume_chk("R8 next", K_NEXT, 1'b0);
        end
    endtask

    task automatic t_write_read();
        enter(1'b1, 1'b0, 1'b0, 16'h1234, 1'b0, 3'd0);
        wr(A_HALT, 16'hFFFE);
        rd_chk("R5 halt bit only", A_HALT, 16'h0000);
        wr(A_IO, 16'hAB5A);
        rd_chk("R5 io low byte", A_IO, 16'h005A);
        wr(A_THI, 16'h5555);
        rd_chk("R5 trap read-only", A_THI, 16'h1234);
        rd_chk("R5 unmapped", 16'h7F04, 16'h0);
        resume_chk("R11 stray value", 4'b0000, 1'b1);
    endtask

    task automatic t_idle_writes();
        wr(A_IO, 16'h00FF);
        wr(A_HALT, 16'h0001);
        rd_chk("R6 io idle", A_IO, 16'h005A);
        rd_chk("R6 halt idle", A_HALT, 16'h0000);
    endtask

    task automatic t_halt_table();
        enter(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 3'd0);
        wr(A_HALT, 16'h0000);
        resume_chk("R8 after halt", K_AFT, 1'b0);
        enter(1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 3'd0);
        wr(A_HALT, 16'h0001);
        resume_chk("R9 illegal halt", 4'b0000, 1'b1);
    endtask

    task automatic t_io();
        enter(1'b1, 1'b1, 1'b0, 16'h0060, 1'b0, 3'd1);
        wr(A_IO, 16'h00FF);
        resume_chk("R10 io reexec", K_IO, 1'b0);
        enter(1'b0, 1'b0, 1'b0, 16'h0060, 1'b0, 3'd7);
        wr(A_IO, 16'h00FF);
        resume_chk("R11 no boundary", 4'b0000, 1'b1);
        enter(1'b0, 1'b1, 1'b0, 16'h0060, 1'b0, 3'd1);
        resume_chk("R10 io clear next", K_NEXT, 1'b0);
    endtask

    task automatic t_nested_stray();
        enter(1'b1, 1'b0, 1'b0, 16'h0011, 1'b1, 3'd3);
        enter(1'b0, 1'b1, 1'b1, 16'h0022, 1'b0, 3'd0);
        rd_chk("R12 halt kept", A_HALT, 16'h0001);
        rd_chk("R12 trap kept", A_THI, 16'h0011);
        resume_chk("R12 first entry wins", K_RH, 1'b0);
        @(negedge clk);
        rsm = 1'b1;
        @(negedge clk);
        rsm = 1'b0;
        check("R12 stray rsm", {31'h0, res_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_entry();
        t_trap_b2b();
        t_classes();
        t_write_read();
        t_idle_writes();
        t_halt_table();
        t_io();
        t_nested_stray();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule